// File: doc/BRIEF.md
# Control-Byte Register Access Front End

This block sits behind a cyclic fieldbus endpoint. Each exchange cycle delivers one control byte and two user-data bytes from the host, and the block answers with one status byte and two data bytes. The top bit of the control byte sets what the other bits mean. When it is clear, the exchange is live process data. The user bytes go straight to the application, the application's input word comes back, two auxiliary output requests are applied and echoed, and a base-frequency pair request is confirmed.

When the top bit is set, the same bytes carry an access to a 64-entry, 16-bit configuration register file. Bits 5 to 0 give the address and bit 6 picks write (1) or read (0). The reply carries the register contents, or the written value, and a status byte that the host can match to its request. The base-frequency selection drives a 32-bit word taken from register pair 36/37 or pair 38/39. A newly requested pair takes effect only at the next reset.

Top module: `ctrlreg_if`

## Requirements
- R1: One cycle after a valid exchange with control bit 7 = 0, status bit 7 = 0 and bits 6, 3, 2 and 1 are 0.
- R2: After a valid process-mode exchange, aux_hi and aux_lo equal control bits 5 and 4, and status bits 5 and 4 echo them. Register-mode exchanges leave aux_hi and aux_lo unchanged.
- R3: After a valid process-mode exchange, pd_out equals data_in and data_out equals pd_in. Register-mode exchanges leave pd_out unchanged.
- R4: One cycle after a valid exchange with control bit 7 = 1, status bit 7 = 1, status bit 6 equals control bit 6 (1 acknowledges a completed write), and status bits 5 to 0 equal the address in control bits 5 to 0.
- R5: A register read (bit 7 = 1, bit 6 = 0) returns the addressed 16-bit entry on data_out, low byte in data_out[7:0], and changes no entry.
- R6: A register write (bit 7 = 1, bit 6 = 1) stores data_in in the addressed entry, changes no other entry, and returns the written value on data_out.
- R7: After reset, status_byte, data_out, pd_out, aux_hi and aux_lo are 0, and entry i of the register file holds 16'h1000 + i.
- R8: After a valid process-mode exchange, status bit 0 equals control bit 0 (1 requests pair 38/39, 0 requests pair 36/37). The request survives reset. base_freq is {entry 39, entry 38} when the pair active since the last reset is 2, and {entry 37, entry 36} otherwise. The active pair changes only during reset.
- R9: In cycles where cyc_valid is low, no output and no register entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_valid | input | 1 | One exchange is present this cycle |
| ctrl_byte | input | 8 | Control byte from the host |
| data_in | input | 16 | Two user-data bytes from the host, low byte in [7:0] |
| pd_in | input | 16 | Process input word from the application |
| status_byte | output | 8 | Status byte to the host |
| data_out | output | 16 | Two data bytes to the host, low byte in [7:0] |
| pd_out | output | 16 | Process output word to the application |
| aux_hi | output | 1 | Auxiliary output request from control bit 5 |
| aux_lo | output | 1 | Auxiliary output request from control bit 4 |
| base_freq | output | 32 | Active base-frequency register pair |

## Verification
The assertions assume one exchange per cycle at most, and that cyc_valid, ctrl_byte and data_in are at defined values at every edge where reset is inactive. The bench drives every input from known values at all times. It issues exchanges with an 80 % probability per cycle, and makes the byte fields random but always defined. Addresses are biased toward the frequency registers, so that writes there show up on base_freq, and directed resets exercise the deferred pair switch.

// File: rtl/ctrlreg_pkg.sv
// Package ctrlreg_pkg
// Shared definitions for the control-byte front end: the byte layout
// constants and the decoded command record passed from the decoder.
// Assumes an 8-bit control byte whose bit 7 selects the mode.
package ctrlreg_pkg;
    localparam int CTRL_W  = 8;
    localparam int ADDR_W  = 6;
    localparam int MODE_B  = 7;
    localparam int WR_B    = 6;
    localparam int AUXH_B  = 5;
    localparam int AUXL_B  = 4;
    localparam int FSEL_B  = 0;

    typedef struct packed {
        logic              is_reg;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic              aux_hi;
        logic              aux_lo;
        logic              fsel;
    } cmd_t;
endpackage

// File: rtl/ctrlreg_decode.sv
// Module ctrlreg_decode
// Splits a control byte into its mode-dependent fields. Purely
// combinational; the caller qualifies the result with its valid strobe.
module ctrlreg_decode
    import ctrlreg_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    output cmd_t              cmd
);
    // Field extraction for both interpretations of bits 6..0.
    always_comb begin
        cmd.is_reg = ctrl[MODE_B];
        cmd.is_wr  = ctrl[MODE_B] & ctrl[WR_B];
        cmd.addr   = ctrl[ADDR_W-1:0];
        cmd.aux_hi = ctrl[AUXH_B];
        cmd.aux_lo = ctrl[AUXL_B];
        cmd.fsel   = ctrl[FSEL_B];
    end
endmodule

// File: rtl/ctrlreg_regfile.sv
// Module ctrlreg_regfile
// Flop-based register file with one write port and three combinational
// read ports (host read plus two for the frequency pair). Each entry
// resets to RST_BASE + index. Assumes write address is in range.
module ctrlreg_regfile #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 6,
    parameter int RST_BASE = 16'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] lo_addr,
    output logic [DATA_W-1:0] lo_data,
    input  logic [ADDR_W-1:0] hi_addr,
    output logic [DATA_W-1:0] hi_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Entry storage: defined reset value, load on addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= DATA_W'(RST_BASE + i);
            else if (we && waddr == ADDR_W'(i))
                mem[i] <= wdata;
        end

        AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && waddr == ADDR_W'(i)) |=> $stable(mem[i])); // R5
    end

    // Read muxes.
    always_comb begin
        rdata   = mem[raddr];
        lo_data = mem[lo_addr];
        hi_data = mem[hi_addr];
    end
endmodule

// File: rtl/ctrlreg_freqsel.sv
// Module ctrlreg_freqsel
// Holds the requested base-frequency pair and the pair in force. The
// request flop has no reset so that it survives one; the active pair is
// copied from it only while reset is asserted.
module ctrlreg_freqsel (
    input  logic clk,
    input  logic rst_n,
    input  logic req_load,
    input  logic req_val,
    output logic active
);
    logic pend = 1'b0;

    // Request capture, kept across reset.
    always_ff @(posedge clk) begin
        if (req_load)
            pend <= req_val;
    end

    // Active pair loads from the request during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= pend;
    end

    AST_FREQ_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(active)); // R8
endmodule

// File: rtl/ctrlreg_if.sv
// Module ctrlreg_if
// Top of the control-byte front end. Registers a reply for every valid
// exchange: process mode forwards data and echoes requests, register
// mode reads or writes the register file. Outputs hold between
// exchanges. Assumes at most one exchange per clock.
module ctrlreg_if
    import ctrlreg_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int RST_BASE = 16'h1000,
    parameter int PAIR1_LO = 36,
    parameter int PAIR2_LO = 38
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_valid,
    input  logic [CTRL_W-1:0]   ctrl_byte,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [DATA_W-1:0]   pd_in,
    output logic [CTRL_W-1:0]   status_byte,
    output logic [DATA_W-1:0]   data_out,
    output logic [DATA_W-1:0]   pd_out,
    output logic                aux_hi,
    output logic                aux_lo,
    output logic [2*DATA_W-1:0] base_freq
);
    localparam logic [ADDR_W-1:0] P1_LO = ADDR_W'(PAIR1_LO);
    localparam logic [ADDR_W-1:0] P1_HI = ADDR_W'(PAIR1_LO + 1);
    localparam logic [ADDR_W-1:0] P2_LO = ADDR_W'(PAIR2_LO);
    localparam logic [ADDR_W-1:0] P2_HI = ADDR_W'(PAIR2_LO + 1);

    cmd_t              cmd;
    logic              pair2;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] f_lo;
    logic [DATA_W-1:0] f_hi;
    logic              pd_cycle;
    logic              rg_cycle;

    ctrlreg_decode u_decode (
        .ctrl (ctrl_byte),
        .cmd  (cmd)
    );

    // Cycle qualification.
    always_comb begin
        pd_cycle = cyc_valid & ~cmd.is_reg;
        rg_cycle = cyc_valid &  cmd.is_reg;
    end

    ctrlreg_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RST_BASE (RST_BASE)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rg_cycle & cmd.is_wr),
        .waddr   (cmd.addr),
        .wdata   (data_in),
        .raddr   (cmd.addr),
        .rdata   (rd_word),
        .lo_addr (pair2 ? P2_LO : P1_LO),
        .lo_data (f_lo),
        .hi_addr (pair2 ? P2_HI : P1_HI),
        .hi_data (f_hi)
    );

    ctrlreg_freqsel u_freqsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_load (pd_cycle),
        .req_val  (cmd.fsel),
        .active   (pair2)
    );

    // Reply and process-output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_byte <= '0;
            data_out    <= '0;
            pd_out      <= '0;
            aux_hi      <= 1'b0;
            aux_lo      <= 1'b0;
        end else if (pd_cycle) begin
            status_byte <= {1'b0, 1'b0, cmd.aux_hi, cmd.aux_lo, 3'b000, cmd.fsel};
            data_out    <= pd_in;
            pd_out      <= data_in;
            aux_hi      <= cmd.aux_hi;
            aux_lo      <= cmd.aux_lo;
        end else if (rg_cycle) begin
            status_byte <= {1'b1, cmd.is_wr, cmd.addr};
            data_out    <= cmd.is_wr ? data_in : rd_word;
        end
    end

    // Frequency word from the active pair.
    always_comb base_freq = {f_hi, f_lo};

    AST_PD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        pd_cycle |=> !status_byte[MODE_B] && !status_byte[WR_B]); // R1
    AST_AUX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        pd_cycle |=> aux_hi == status_byte[AUXH_B] && aux_lo == status_byte[AUXL_B]); // R2
    AST_REG_HOLD_PD: assert property (@(posedge clk) disable iff (!rst_n)
        rg_cycle |=> $stable(pd_out) && $stable(aux_hi) && $stable(aux_lo)); // R3
    AST_REG_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        rg_cycle |=> status_byte[MODE_B] && status_byte[ADDR_W-1:0] == $past(ctrl_byte[ADDR_W-1:0])); // R4
    AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_cycle && cmd.is_wr) |=> data_out == $past(data_in)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> $stable(status_byte) && $stable(data_out) && $stable(pd_out)); // R9
endmodule

// File: tb/ctrlreg_if_tb.sv
// Bench for ctrlreg_if: seeded random exchanges mixed with directed
// corner cases, compared against a behavioural model kept here.
module ctrlreg_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [7:0]  ctrl_byte = '0;
    logic [15:0] data_in = '0;
    logic [15:0] pd_in = '0;
    logic [7:0]  status_byte;
    logic [15:0] data_out;
    logic [15:0] pd_out;
    logic        aux_hi;
    logic        aux_lo;
    logic [31:0] base_freq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_reg [64];
    logic [7:0]  m_st;
    logic [15:0] m_dout, m_pdout;
    logic        m_ah, m_al, m_pend, m_act;

    always #4 clk = ~clk;

    ctrlreg_if u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .ctrl_byte(ctrl_byte),
        .data_in(data_in), .pd_in(pd_in), .status_byte(status_byte),
        .data_out(data_out), .pd_out(pd_out), .aux_hi(aux_hi), .aux_lo(aux_lo),
        .base_freq(base_freq)
    );

    function automatic logic [15:0] reg_default(int i);
        return 16'h1000 + 16'(i);
    endfunction

    function automatic logic [31:0] exp_freq();
        return m_act ? {m_reg[39], m_reg[38]} : {m_reg[37], m_reg[36]};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " status"}, 32'(status_byte), 32'(m_st));
        chk({tag, " data_out"}, 32'(data_out), 32'(m_dout));
        chk("R3 pd_out", 32'(pd_out), 32'(m_pdout));
        chk("R2 aux", {30'd0, aux_hi, aux_lo}, {30'd0, m_ah, m_al});
        chk("R8 base_freq", base_freq, exp_freq());
    endtask

    // Apply one cycle starting at a negedge, update model, check at next negedge.
    task automatic cycle(logic v, logic [7:0] c, logic [15:0] d, logic [15:0] p);
        string tag;
        cyc_valid = v; ctrl_byte = c; data_in = d; pd_in = p;
        @(posedge clk);
        tag = "R9";
        if (v && !c[7]) begin
            m_st = {2'b00, c[5], c[4], 3'b000, c[0]};
            m_dout = p; m_pdout = d; m_ah = c[5]; m_al = c[4]; m_pend = c[0];
            tag = "R1";
        end else if (v) begin
            m_st = {1'b1, c[6], c[5:0]};
            if (c[6]) begin
                m_reg[c[5:0]] = d; m_dout = d; tag = "R6";
            end else begin
                m_dout = m_reg[c[5:0]]; tag = "R5";
            end
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        for (int i = 0; i < 64; i++) m_reg[i] = reg_default(i);
        m_st = '0; m_dout = '0; m_pdout = '0; m_ah = 0; m_al = 0; m_act = m_pend;
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R7");
    endtask

    task automatic read_all_check();
        for (int i = 0; i < 64; i++) begin
            cycle(1'b1, {2'b10, 6'(i)}, 16'hFFFF, 16'h0);
            chk("R4 tag", 32'(status_byte), {24'd0, 2'b10, 6'(i)});
        end
    endtask

    initial begin
        logic [7:0] c;
        int r;
        r = $urandom(32'd20240611);
        m_pend = 1'b0; m_act = 1'b0;
        @(negedge clk);
        do_reset();
        read_all_check();                          // R7 defaults, R5
        // Directed: process echo, aux patterns
        cycle(1'b1, 8'b0011_0001, 16'hA55A, 16'h1234); // R1 R2 R8
        cycle(1'b1, 8'b0001_0000, 16'h0F0F, 16'h4321); // R2
        cycle(1'b0, 8'hFF, 16'hDEAD, 16'hBEEF);         // R9 idle
        // Directed: write boundary addresses and frequency pairs
        cycle(1'b1, 8'b1100_0000, 16'hC0DE, 16'h0);     // R6 addr 0
        cycle(1'b1, 8'b1111_1111, 16'h7777, 16'h0);     // R6 addr 63
        cycle(1'b1, 8'b1110_0110, 16'h2626, 16'h0);     // R6 addr 38
        cycle(1'b1, 8'b1110_0111, 16'h2727, 16'h0);     // R6 addr 39
        cycle(1'b1, 8'b1000_0000, 16'h0, 16'h0);        // R5 addr 0
        chk("R5 readback", 32'(data_out), 32'h0000_C0DE);
        // Pair 2 requested: no effect until reset (R8)
        cycle(1'b1, 8'b0000_0001, 16'h0, 16'h0);
        chk("R8 no early switch", base_freq, {m_reg[37], m_reg[36]});
        do_reset();
        chk("R8 pair2 after reset", base_freq, {16'h1027, 16'h1026});
        cycle(1'b1, 8'b1110_0110, 16'h5A5A, 16'h0);     // R8 write active reg
        // Random phase
        for (int k = 0; k < 3000; k++) begin
            c = 8'($urandom);
            if (($urandom % 3) == 0) c[5:0] = 6'(36 + ($urandom % 4));
            cycle(($urandom % 10) < 8, c, 16'($urandom), 16'($urandom));
            if (k % 1000 == 999) do_reset();
        end
        // Back to pair 1
        cycle(1'b1, 8'b0000_0000, 16'h0, 16'h0);
        do_reset();
        chk("R8 pair1 after reset", base_freq, {16'h1025, 16'h1024});
        read_all_check();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule